// File: doc/BRIEF.md
# Vertical Three-Tap Sharpening Filter

This block sharpens an image along the slow-scan axis, one pixel at a time. Each accepted input cycle brings three 8-bit samples from the same column. The samples come from the line above, the centre line and the line below. The block returns one corrected centre pixel. The correction is the centre's second difference against its two vertical neighbours, 2N − (A + B). That difference is scaled by a programmable gain, rounded, added to the centre value and saturated to the pixel range.

The samples are fed by external line stores that present the three lines together. The block accepts a new column on every clock. The result appears two clocks later with its own valid flag. The gain is sampled together with the pixel, so it may change on any cycle without disturbing pixels already in flight.

Top module: `vsharp_filter`

## Requirements
- R1: A pixel presented with `in_valid` high appears on `out_pix` with `out_valid` high exactly two clock cycles later, and the block accepts a new pixel on every clock.
- R2: The correction term is the signed difference D = 2·`pix_cur` − (`pix_prev` + `pix_next`), evaluated without loss over its full range −510 to +510.
- R3: `gain` is an unsigned 8-bit fixed-point number with 4 integer and 4 fractional bits, so its value is `gain`/16. It is captured on the same cycle as the pixel it scales.
- R4: The scaled term is rounded to nearest with ties toward positive infinity: r = floor((D·`gain` + 8) / 16).
- R5: `out_pix` equals `pix_cur` + r, saturated to the range 0 to 255.
- R6: With `gain` equal to zero the output equals `pix_cur` exactly.
- R7: The correction never points the wrong way. When D ≥ 0 the output is not below `pix_cur`, and when D ≤ 0 the output is not above it.
- R8: Reset is synchronous and active high. One clock after reset is sampled high, `out_valid` is 0 and `out_pix` is 0.
- R9: A cycle with `in_valid` low produces `out_valid` low two cycles later. During such a cycle `out_pix` keeps the last valid result, and the data inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input column is valid this cycle |
| pix_prev | input | 8 | Sample from the line above (A) |
| pix_cur | input | 8 | Sample from the centre line (N) |
| pix_next | input | 8 | Sample from the line below (B) |
| gain | input | 8 | Sharpening gain, unsigned 4.4 fixed point |
| out_valid | output | 1 | Output pixel is valid |
| out_pix | output | 8 | Sharpened, saturated pixel |

## Verification
Some properties are checked on every cycle by assertions. These are the two-stage alignment of the valid flag, the reset value, the hold of `out_pix` across bubbles, the exact pass-through at zero gain, and the sign agreement between the second difference and the correction. The exact arithmetic can only be shown by the bench's sweeps. This covers the rounding of half-way products, saturation at both ends, and per-cycle gain changes. The sweeps cover every gain code against a grid of extreme and mid-range pixel triples, with bubbles mixed in.

// File: rtl/vsharp_pkg.sv
package vsharp_pkg;
  localparam int PIX_W_DEF  = 8;
  localparam int K_INT_DEF  = 4;
  localparam int K_FRAC_DEF = 4;
endpackage

// File: rtl/vsharp_diff_stage.sv
module vsharp_diff_stage #(
  parameter int PIX_W = vsharp_pkg::PIX_W_DEF,
  parameter int K_W   = vsharp_pkg::K_INT_DEF + vsharp_pkg::K_FRAC_DEF,
  localparam int DIFF_W = PIX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         a_in,
  input  logic [PIX_W-1:0]         n_in,
  input  logic [PIX_W-1:0]         b_in,
  input  logic [K_W-1:0]           k_in,
  output logic                     v1,
  output logic signed [DIFF_W-1:0] diff1,
  output logic [PIX_W-1:0]         n1,
  output logic [K_W-1:0]           k1
);
  logic [DIFF_W-1:0] twice_n;
  logic [DIFF_W-1:0] side_sum;
  logic signed [DIFF_W-1:0] diff_c;

  always_comb begin
    twice_n  = {1'b0, n_in, 1'b0};
    side_sum = {2'b00, a_in} + {2'b00, b_in};
    diff_c   = $signed(twice_n - side_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      diff1 <= '0;
      n1    <= '0;
      k1    <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        diff1 <= diff_c;
        n1    <= n_in;
        k1    <= k_in;
      end
    end
  end

  // R1
  stage1_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v1 == $past(in_valid)));
endmodule

// File: rtl/vsharp_gain_stage.sv
module vsharp_gain_stage #(
  parameter int PIX_W  = vsharp_pkg::PIX_W_DEF,
  parameter int K_FRAC = vsharp_pkg::K_FRAC_DEF,
  parameter int K_W    = vsharp_pkg::K_INT_DEF + vsharp_pkg::K_FRAC_DEF,
  localparam int DIFF_W = PIX_W + 2,
  localparam int PROD_W = DIFF_W + K_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     v1,
  input  logic signed [DIFF_W-1:0] diff1,
  input  logic [PIX_W-1:0]         n1,
  input  logic [K_W-1:0]           k1,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_pix
);
  localparam logic signed [PROD_W-1:0] ROUND_OFS = PROD_W'(1 << (K_FRAC - 1));
  localparam logic signed [PROD_W-1:0] PIX_MAX   = PROD_W'((1 << PIX_W) - 1);

  logic signed [PROD_W-1:0] d_ext, k_ext, prod, rnd, total;
  logic [PIX_W-1:0] sat_c;

  always_comb begin
    d_ext = {{(PROD_W-DIFF_W){diff1[DIFF_W-1]}}, diff1};
    k_ext = {{(PROD_W-K_W){1'b0}}, k1};
    prod  = d_ext * k_ext;
    rnd   = (prod + ROUND_OFS) >>> K_FRAC;
    total = $signed({{(PROD_W-PIX_W){1'b0}}, n1}) + rnd;
    if (total < 0)
      sat_c = '0;
    else if (total > PIX_MAX)
      sat_c = '1;
    else
      sat_c = total[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_pix <= sat_c;
    end
  end

  // R1
  stage2_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(v1)));
  // R6
  zero_gain_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (v1 && k1 == '0) |=> (out_pix == $past(n1)));
  // R7
  lift_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (v1 && diff1 >= 0) |=> (out_pix >= $past(n1)));
  // R7
  drop_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (v1 && diff1 <= 0) |=> (out_pix <= $past(n1)));
  // R9
  bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !out_valid) |-> $stable(out_pix));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == '0));
endmodule

// File: rtl/vsharp_filter.sv
module vsharp_filter #(
  parameter int PIX_W  = vsharp_pkg::PIX_W_DEF,
  parameter int K_INT  = vsharp_pkg::K_INT_DEF,
  parameter int K_FRAC = vsharp_pkg::K_FRAC_DEF,
  localparam int K_W    = K_INT + K_FRAC,
  localparam int DIFF_W = PIX_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_prev,
  input  logic [PIX_W-1:0] pix_cur,
  input  logic [PIX_W-1:0] pix_next,
  input  logic [K_W-1:0]   gain,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic                     v1;
  logic signed [DIFF_W-1:0] diff1;
  logic [PIX_W-1:0]         n1;
  logic [K_W-1:0]           k1;

  vsharp_diff_stage #(.PIX_W(PIX_W), .K_W(K_W)) u_diff (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_in(pix_prev), .n_in(pix_cur), .b_in(pix_next), .k_in(gain),
    .v1(v1), .diff1(diff1), .n1(n1), .k1(k1)
  );

  vsharp_gain_stage #(.PIX_W(PIX_W), .K_FRAC(K_FRAC), .K_W(K_W)) u_gain (
    .clk(clk), .rst(rst), .v1(v1), .diff1(diff1), .n1(n1), .k1(k1),
    .out_valid(out_valid), .out_pix(out_pix)
  );
endmodule

// File: tb/sim_vsharp_filter.sv
module sim_vsharp_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] pix_prev = '0, pix_cur = '0, pix_next = '0, gain = '0;
  logic out_valid;
  logic [7:0] out_pix;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  bit       vq0 = 1'b0, vq1 = 1'b0;
  int       eq0 = 0, eq1 = 0;
  int       last_pix = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsharp_filter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .pix_prev(pix_prev), .pix_cur(pix_cur), .pix_next(pix_next), .gain(gain),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic int model(int a, int n, int b, int k);
    int d, p, q, r, s;
    d = 2*n - a - b;
    p = d * k;
    q = p + 8;
    r = (q >= 0) ? q / 16 : -((-q + 15) / 16);
    s = n + r;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: check the result due now, then present a new input.
  task automatic step(bit v, int a, int n, int b, int k);
    @(negedge clk);
    check(out_valid == vq1, "R1 valid timing", int'(out_valid), int'(vq1));
    if (vq1) begin
      // R2 R3 R4 R5
      check(int'(out_pix) == eq1, "R5 value", int'(out_pix), eq1);
      last_pix = eq1;
    end else begin
      check(int'(out_pix) == last_pix, "R9 hold", int'(out_pix), last_pix);
    end
    vq1 = vq0; eq1 = eq0;
    vq0 = v;   eq0 = model(a, n, b, k);
    in_valid = v;
    pix_prev = 8'(a); pix_cur = 8'(n); pix_next = 8'(b); gain = 8'(k);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int grid[7] = '{0, 1, 63, 128, 200, 254, 255};
    int cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8
    check(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
    check(out_pix == 8'd0, "R8 reset pix", int'(out_pix), 0);

    // R6: zero gain passes centre through
    step(1, 255, 7, 255, 0);
    // R4: tie rounding, D=1, K=8 -> +0.5 -> +1; D=-1, K=8 -> -0.5 -> 0
    step(1, 100, 100, 99, 8);
    step(1, 100, 100, 101, 8);
    // R5: saturation high and low
    step(1, 0, 255, 0, 255);
    step(1, 255, 0, 255, 255);
    // R9: bubble with garbage data
    step(0, 3, 250, 9, 200);
    step(0, 77, 1, 5, 16);
    step(1, 10, 20, 30, 16);

    // R1 R2 R3: sweep every gain over a pixel grid, bubbles mixed in
    for (int k = 0; k < 256; k++)
      for (int ia = 0; ia < 7; ia++)
        for (int in_ = 0; in_ < 7; in_++)
          for (int ib = 0; ib < 7; ib++) begin
            cnt++;
            if (cnt % 11 == 0) step(0, grid[ib], grid[ia], grid[in_], k ^ 8'h5a);
            step(1, grid[ia], grid[in_], grid[ib], k);
          end

    // R8: reset in the middle of a stream clears the output
    step(1, 0, 200, 0, 255);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R8 mid reset valid", int'(out_valid), 0);
    check(out_pix == 8'd0, "R8 mid reset pix", int'(out_pix), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule